// File: doc/BRIEF.md
# User-Readable Hardware Register Unit

This block answers read requests for a small set of CPU information registers, picked by a 5-bit register index. Register 0 gives the number of the CPU that serves the request. Register 1 gives the cache-synchronize step, which is the address increment software uses when it walks a range of freshly written code. The step is the smaller of the instruction-cache and data-cache line sizes in bytes. A step of zero tells software that no synchronize operations are needed.

A privileged write port loads a 32-bit enable mask. Bit n of the mask opens register n to user-mode reads. Kernel-mode requests ignore the mask. Each request gets a registered response one cycle later. The response carries either the register value or an access fault with zero data.

Top module: `hwr_unit`

## Requirements
- R1: After reset the enable mask is all zeros, so every user-mode read of index 0 or 1 returns fault=1 until the mask is written.
- R2: A mask write (wr_en=1) takes effect in the cycle after the write. A read issued in the same cycle as the write is judged against the old mask.
- R3: A user-mode read (req_kernel=0) of index n in {0,1} succeeds (fault=0) exactly when mask bit n is 1.
- R4: A kernel-mode read (req_kernel=1) of index 0 or 1 never faults, whatever the mask holds.
- R5: A successful read of index 0 returns cpu_id zero-extended to 32 bits.
- R6: A successful read of index 1 returns min(iline_bytes, dline_bytes) zero-extended to 32 bits. The result is 0 when either size is 0.
- R7: A read of any index from 2 to 31 returns fault=1 in both modes.
- R8: Every faulting response has rsp_data equal to 0.
- R9: rsp_valid is 1 in the cycle after a cycle with req_valid=1 and is 0 otherwise. When rsp_valid=0, both rsp_data and rsp_fault are 0, and this includes the cycles under reset.
- R10: Mask bits 2 to 31 have no effect. A user read of index 2 to 31 faults even when its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Privileged enable-mask write strobe |
| wr_mask | input | 32 | New enable mask value |
| req_valid | input | 1 | Read request strobe |
| req_idx | input | 5 | Register index |
| req_kernel | input | 1 | 1 = privileged requester, 0 = user |
| cpu_id | input | 10 | CPU number configuration field |
| iline_bytes | input | 8 | Instruction-cache line size in bytes |
| dline_bytes | input | 8 | Data-cache line size in bytes |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_data | output | 32 | Read data, zero on fault |
| rsp_fault | output | 1 | Access fault |

## Verification
On every cycle the assertions check the following:
- that a response follows each request and only a request;
- that faulting responses carry zero data;
- that unimplemented indexes always fault;
- that kernel reads of implemented registers never fault;
- that the mask changes only on a write.

Some behaviour is visible only in the bench's scenarios, because the bench compares against its own model. This covers the returned values themselves, including the minimum of the two line sizes and the zero-step case. It also covers the one-cycle lag of a mask write against a read in the same cycle, and the closed-by-default state after reset.

// File: rtl/hwr_pkg.sv
package hwr_pkg;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 5;
    localparam int MASK_W   = 1 << IDX_W;
    localparam int NUM_IMPL = 2;

    localparam logic [IDX_W-1:0] IDX_CPU  = 5'd0;
    localparam logic [IDX_W-1:0] IDX_STEP = 5'd1;

    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [DATA_W-1:0] data;
    } rsp_t;
endpackage

// File: rtl/hwr_enable_mask.sv
module hwr_enable_mask
    import hwr_pkg::*;
#(
    parameter int W = MASK_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_mask,
    output logic [W-1:0] mask
);
    logic [W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_en) mask_d = wr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mask_q == $past(wr_mask));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/hwr_step_calc.sv
module hwr_step_calc #(
    parameter int LINE_W = 8
) (
    input  logic [LINE_W-1:0] iline,
    input  logic [LINE_W-1:0] dline,
    output logic [LINE_W-1:0] step
);
    logic i_smaller;

    always_comb begin
        i_smaller = (iline < dline);
        step      = i_smaller ? iline : dline;
    end

    // R6
    always_comb begin
        step_min_chk: assert (step <= iline && step <= dline);
    end
endmodule

// File: rtl/hwr_read_port.sv
module hwr_read_port
    import hwr_pkg::*;
#(
    parameter int CPU_W  = 10,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              req_kernel,
    input  logic [MASK_W-1:0] mask,
    input  logic [CPU_W-1:0]  cpu_id,
    input  logic [LINE_W-1:0] step,
    output rsp_t              rsp
);
    logic [DATA_W-1:0] reg_val [NUM_IMPL];

    for (genvar g = 0; g < NUM_IMPL; g++) begin : g_src
        if (g == int'(IDX_CPU)) begin : g_cpu
            assign reg_val[g] = DATA_W'(cpu_id);
        end else if (g == int'(IDX_STEP)) begin : g_step
            assign reg_val[g] = DATA_W'(step);
        end else begin : g_none
            assign reg_val[g] = '0;
        end
    end

    rsp_t rsp_d, rsp_q;
    logic implemented, permitted;

    always_comb begin
        implemented = (int'(req_idx) < NUM_IMPL);
        permitted   = implemented && (req_kernel || mask[req_idx]);
        rsp_d       = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = !permitted;
            if (permitted) rsp_d.data = reg_val[req_idx[0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp = rsp_q;

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_q.valid);

    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_q.valid && !rsp_q.fault && rsp_q.data == '0);

    // R8
    fault_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_q.fault |-> rsp_q.data == '0);

    // R7
    unimpl_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_idx) >= NUM_IMPL) |=> rsp_q.fault);

    // R4
    kernel_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kernel && int'(req_idx) < NUM_IMPL) |=> !rsp_q.fault);
endmodule

// File: rtl/hwr_unit.sv
module hwr_unit
    import hwr_pkg::*;
#(
    parameter int CPU_W  = 10,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_mask,
    input  logic              req_valid,
    input  logic [4:0]        req_idx,
    input  logic              req_kernel,
    input  logic [CPU_W-1:0]  cpu_id,
    input  logic [LINE_W-1:0] iline_bytes,
    input  logic [LINE_W-1:0] dline_bytes,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              rsp_fault
);
    logic [MASK_W-1:0] mask;
    logic [LINE_W-1:0] step;
    rsp_t              rsp;

    hwr_enable_mask #(.W(MASK_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .mask    (mask)
    );

    hwr_step_calc #(.LINE_W(LINE_W)) u_step (
        .iline (iline_bytes),
        .dline (dline_bytes),
        .step  (step)
    );

    hwr_read_port #(.CPU_W(CPU_W), .LINE_W(LINE_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_idx    (req_idx),
        .req_kernel (req_kernel),
        .mask       (mask),
        .cpu_id     (cpu_id),
        .step       (step),
        .rsp        (rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_fault = rsp.fault;
    assign rsp_data  = rsp.data;
endmodule

// File: tb/sim_hwr_unit.sv
`timescale 1ns/1ps
module sim_hwr_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [31:0] wr_mask = 0;
    logic        req_valid = 0;
    logic [4:0]  req_idx = 0;
    logic        req_kernel = 0;
    logic [9:0]  cpu_id = 0;
    logic [7:0]  iline_bytes = 0;
    logic [7:0]  dline_bytes = 0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_fault;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hwr_unit u0 (.*);

    // reference model
    bit [31:0] m_mask = 0;
    bit        m_written = 0;
    bit        m_wr_last = 0;
    bit        e_valid = 0, e_fault = 0;
    bit [31:0] e_data = 0;
    string     e_tag = "R9";
    bit        model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 0; m_written = 0; m_wr_last = 0;
            e_valid = 0; e_fault = 0; e_data = 0; e_tag = "R9";
        end else begin
            bit impl, ok;
            int mn;
            e_valid = req_valid; e_fault = 0; e_data = 0;
            if (!req_valid) e_tag = "R9";
            else begin
                impl = req_idx < 2;
                ok = impl && (req_kernel || m_mask[req_idx]);
                e_fault = !ok;
                mn = (iline_bytes < dline_bytes) ? iline_bytes : dline_bytes;
                if (ok) e_data = (req_idx == 0) ? 32'(cpu_id) : 32'(mn);
                if (!impl) e_tag = m_mask[req_idx] ? "R10" : "R7";
                else if (req_kernel) e_tag = !m_mask[req_idx] ? "R4" : (req_idx == 0 ? "R5" : "R6");
                else if (wr_en || m_wr_last) e_tag = "R2";
                else if (!m_written) e_tag = "R1";
                else if (ok) e_tag = (req_idx == 0) ? "R5" : "R3";
                else e_tag = "R8";
            end
            m_wr_last = wr_en;
            if (wr_en) begin m_mask = wr_mask; m_written = 1; end
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            compared++;
            if (rsp_valid !== e_valid || rsp_fault !== e_fault || rsp_data !== e_data) begin
                mismatched++;
                $display("FAIL %s: got v=%0b f=%0b d=%h expected v=%0b f=%0b d=%h",
                         e_tag, rsp_valid, rsp_fault, rsp_data, e_valid, e_fault, e_data);
            end
        end
    end

    task automatic rd(input logic [4:0] idx, input logic k);
        @(negedge clk);
        wr_en = 0; req_valid = 1; req_idx = idx; req_kernel = k;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 0; req_valid = 0;
    endtask

    task automatic wr(input logic [31:0] m);
        @(negedge clk);
        wr_en = 1; wr_mask = m; req_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        cpu_id = 10'd517; iline_bytes = 8'd32; dline_bytes = 8'd64;
        repeat (3) @(negedge clk);
        // R9 reset state
        compared++;
        if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_data !== 0) begin
            mismatched++;
            $display("FAIL R9 reset: got v=%0b f=%0b d=%h expected 0 0 0", rsp_valid, rsp_fault, rsp_data);
        end
        rst_n = 1;
        model_on = 1;
        // R1: closed after reset
        rd(0, 0); rd(1, 0); idle();
        // R4 R5 R6 kernel reads
        rd(0, 1); rd(1, 1);
        dline_bytes = 8'd16; rd(1, 1);
        // R7 unimplemented indexes
        rd(2, 1); rd(31, 0); rd(17, 1);
        // R2 same-cycle write uses old mask
        @(negedge clk);
        wr_en = 1; wr_mask = 32'h1; req_valid = 1; req_idx = 0; req_kernel = 0;
        rd(0, 0);
        // R8 denied index 1
        rd(1, 0);
        // R3 open index 1
        wr(32'h3); rd(1, 0); rd(0, 0);
        // R10 upper bits ignored
        wr(32'hFFFF_FFFF); rd(5, 0); rd(2, 0); rd(31, 0);
        // R6 zero step
        iline_bytes = 8'd0; rd(1, 0); rd(1, 1);
        iline_bytes = 8'd128; dline_bytes = 8'd128; rd(1, 0);
        // R4 kernel with mask cleared
        wr(32'h0); rd(0, 1); rd(1, 1); rd(0, 0);
        idle(); idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            wr_en = ($urandom % 6) == 0;
            wr_mask = $urandom;
            req_valid = ($urandom % 4) != 0;
            req_idx = ($urandom % 3 == 0) ? 5'($urandom) : 5'($urandom % 2);
            req_kernel = $urandom % 2;
            cpu_id = 10'($urandom);
            iline_bytes = 8'($urandom % 4 == 0 ? 0 : $urandom);
            dline_bytes = 8'($urandom);
        end
        idle(); idle();
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule